// File: doc/BRIEF.md
# Decimal Adjust Unit

This block is one slice of an integer ALU. It repairs an 8-bit accumulator value after decimal arithmetic, where each digit lives in one nibble. It receives the accumulator as a high byte and a low byte, plus the incoming auxiliary-carry and carry flags. A 2-bit select chooses one of four corrections:

- fix up after adding unpacked digits;
- fix up after subtracting unpacked digits;
- prepare two unpacked digits for a division by merging them into one binary byte;
- fix up after adding packed digits.

Each correction has its own rule for updating the flags.

The unit samples its inputs only on a cycle in which the strobe is high. The corrected accumulator and the AF, CF, SF, ZF and PF flags appear on registered outputs after the next clock edge. The outputs hold their value until the next strobe. Flags that a correction leaves undefined are driven to 0.

Top module: `dec_adj_unit`

## Requirements
- R1: While reset is active, and afterwards until the first strobe, the accumulator output and all five flag outputs are 0.
- R2: Inputs are captured only on a clock edge where `adjValid` is 1, and the results appear after that edge. Without a strobe, every output keeps its value whatever the inputs do.
- R3: Unpacked add fix (`adjOp` = 2'b00). When the low nibble of the low byte is above 9, or AF is 1: add 6 to the low byte (modulo 256), add 1 to the high byte (modulo 256), and set AF and CF to 1. Otherwise both bytes are unchanged and AF and CF are 0.
- R4: Unpacked subtract fix (`adjOp` = 2'b01). It uses the same condition as R3. When the condition holds it subtracts 6 from the low byte and 1 from the high byte (modulo 256), and sets AF and CF to 1. Otherwise both bytes are unchanged and AF and CF are 0.
- R5: After either unpacked fix, bits 7:4 of the low byte are 0, and SF, ZF and PF are 0.
- R6: Division preparation (`adjOp` = 2'b10). The low byte becomes (10 × high + low) modulo 256, and the high byte becomes 0.
- R7: After division preparation, AF and CF are 0, and SF, ZF and PF follow the resulting low byte.
- R8: Packed add fix (`adjOp` = 2'b11), first step. When the low nibble is above 9, or AF is 1, add 6 to the low byte and set AF to 1. Otherwise AF is 0.
- R9: Packed add fix, second step. When the original low byte, taken before the first step, is above 0x99, or CF is 1, add 0x60 to the result of the first step and set CF to 1. Otherwise CF is 0.
- R10: After the packed add fix, the high byte is unchanged. SF is bit 7 of the result low byte, and ZF is 1 exactly when the result low byte is 0.
- R11: Whenever PF is updated from the result, it is 1 when the result low byte contains an even number of one bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| adjValid | input | 1 | Capture strobe |
| adjOp | input | 2 | Correction select: 00 unpacked add, 01 unpacked subtract, 10 division preparation, 11 packed add |
| accIn | input | 16 | Accumulator pair: high byte [15:8], low byte [7:0] |
| afIn | input | 1 | Incoming auxiliary-carry flag |
| cfIn | input | 1 | Incoming carry flag |
| accOut | output | 16 | Corrected accumulator pair |
| afOut | output | 1 | Updated auxiliary-carry flag |
| cfOut | output | 1 | Updated carry flag |
| sfOut | output | 1 | Updated sign flag |
| zfOut | output | 1 | Updated zero flag |
| pfOut | output | 1 | Updated parity flag |

## Verification
The bench builds the unit with its defaults: byte width 8 and radix 10. With these values, hand-computed byte values reach every wrap-around of interest:
- the low byte overflowing past 0xFF during the unpacked add fix;
- the high byte underflowing to 0xFF during the unpacked subtract fix;
- the product 10 × high exceeding a byte during division preparation;
- the packed fix where both steps apply, and the case where the first step lifts the nibble but the original byte does not trigger the second step.

Holding the strobe low while the inputs change shows that the registered outputs keep their value.

// File: rtl/dec_adj_pkg.sv
package dec_adj_pkg;

  typedef enum logic [1:0] {
    OP_UNP_ADD = 2'b00,
    OP_UNP_SUB = 2'b01,
    OP_PRE_DIV = 2'b10,
    OP_PKD_ADD = 2'b11
  } adjOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic unpAdd;
    logic unpSub;
    logic preDiv;
    logic pkdAdd;
  } adjStrobe_t;

endpackage

// File: rtl/dec_adj_ctrl.sv
module dec_adj_ctrl
  import dec_adj_pkg::*;
(
  input  logic       adjValid,
  input  logic [1:0] adjOp,
  output adjStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    strobe.load = adjValid;
    if (adjValid) begin
      case (adjOp_e'(adjOp))
        OP_UNP_ADD: strobe.unpAdd = 1'b1;
        OP_UNP_SUB: strobe.unpSub = 1'b1;
        OP_PRE_DIV: strobe.preDiv = 1'b1;
        default:    strobe.pkdAdd = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/dec_adj_datapath.sv
module dec_adj_datapath
  import dec_adj_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int RADIX  = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  adjStrobe_t          strobe,
  input  logic [2*BYTE_W-1:0] accIn,
  input  logic                afIn,
  input  logic                cfIn,
  output logic [2*BYTE_W-1:0] accOut,
  output logic                afOut,
  output logic                cfOut,
  output logic                sfOut,
  output logic                zfOut,
  output logic                pfOut
);

  localparam int NIB_W = BYTE_W / 2;
  localparam logic [NIB_W-1:0]  DIGIT_MAX = NIB_W'(RADIX - 1);
  localparam logic [BYTE_W-1:0] LOW_FIX   = BYTE_W'(16 - RADIX);
  localparam logic [BYTE_W-1:0] HIGH_FIX  = LOW_FIX << NIB_W;
  localparam logic [BYTE_W-1:0] PAIR_MAX  = (BYTE_W'(RADIX - 1) << NIB_W) | BYTE_W'(RADIX - 1);
  localparam logic [BYTE_W-1:0] RADIX_V   = BYTE_W'(RADIX);
  localparam logic [BYTE_W-1:0] ONE_V     = BYTE_W'(1);

  logic [BYTE_W-1:0] hiIn, loIn;
  logic              lowFix, upFix;
  logic [BYTE_W-1:0] unpLo, unpHi, unpLoSel, unpLoMasked, unpHiSel;
  logic [BYTE_W-1:0] pkdStep1, pkdLo;
  logic [BYTE_W-1:0] divLo;
  logic [BYTE_W-1:0] nextLo, nextHi;
  logic              nextAf, nextCf, useResFlags;

  assign hiIn   = accIn[2*BYTE_W-1:BYTE_W];
  assign loIn   = accIn[BYTE_W-1:0];
  assign lowFix = (loIn[NIB_W-1:0] > DIGIT_MAX) | afIn;
  assign upFix  = (loIn > PAIR_MAX) | cfIn;

  // unpacked add / subtract share one path
  assign unpLo       = strobe.unpSub ? (loIn - LOW_FIX) : (loIn + LOW_FIX);
  assign unpHi       = strobe.unpSub ? (hiIn - ONE_V)   : (hiIn + ONE_V);
  assign unpLoSel    = lowFix ? unpLo : loIn;
  assign unpHiSel    = lowFix ? unpHi : hiIn;
  assign unpLoMasked = {{(BYTE_W-NIB_W){1'b0}}, unpLoSel[NIB_W-1:0]};

  // packed add: second step keys off the original byte
  assign pkdStep1 = lowFix ? (loIn + LOW_FIX) : loIn;
  assign pkdLo    = upFix ? (pkdStep1 + HIGH_FIX) : pkdStep1;

  // division preparation: recombine two digits
  assign divLo = hiIn * RADIX_V + loIn;

  always_comb begin
    nextLo      = pkdLo;
    nextHi      = hiIn;
    nextAf      = lowFix;
    nextCf      = upFix;
    useResFlags = 1'b1;
    if (strobe.unpAdd || strobe.unpSub) begin
      nextLo      = unpLoMasked;
      nextHi      = unpHiSel;
      nextAf      = lowFix;
      nextCf      = lowFix;
      useResFlags = 1'b0;
    end else if (strobe.preDiv) begin
      nextLo = divLo;
      nextHi = '0;
      nextAf = 1'b0;
      nextCf = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accOut <= '0;
      afOut  <= 1'b0;
      cfOut  <= 1'b0;
      sfOut  <= 1'b0;
      zfOut  <= 1'b0;
      pfOut  <= 1'b0;
    end else if (strobe.load) begin
      accOut <= {nextHi, nextLo};
      afOut  <= nextAf;
      cfOut  <= nextCf;
      sfOut  <= useResFlags & nextLo[BYTE_W-1];
      zfOut  <= useResFlags & (nextLo == '0);
      pfOut  <= useResFlags & ~(^nextLo);
    end
  end

endmodule

// File: rtl/dec_adj_unit.sv
module dec_adj_unit
  import dec_adj_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int RADIX  = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                adjValid,
  input  logic [1:0]          adjOp,
  input  logic [2*BYTE_W-1:0] accIn,
  input  logic                afIn,
  input  logic                cfIn,
  output logic [2*BYTE_W-1:0] accOut,
  output logic                afOut,
  output logic                cfOut,
  output logic                sfOut,
  output logic                zfOut,
  output logic                pfOut
);

  adjStrobe_t strobe;

  dec_adj_ctrl u_ctrl (
    .adjValid (adjValid),
    .adjOp    (adjOp),
    .strobe   (strobe)
  );

  dec_adj_datapath #(.BYTE_W(BYTE_W), .RADIX(RADIX)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .accIn  (accIn),
    .afIn   (afIn),
    .cfIn   (cfIn),
    .accOut (accOut),
    .afOut  (afOut),
    .cfOut  (cfOut),
    .sfOut  (sfOut),
    .zfOut  (zfOut),
    .pfOut  (pfOut)
  );

endmodule

// File: rtl/dec_adj_checker.sv
module dec_adj_checker #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                adjValid,
  input logic [1:0]          adjOp,
  input logic [2*BYTE_W-1:0] accIn,
  input logic [2*BYTE_W-1:0] accOut,
  input logic                afOut,
  input logic                cfOut,
  input logic                sfOut,
  input logic                zfOut,
  input logic                pfOut
);

  localparam int NIB_W = BYTE_W / 2;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !adjValid |=> ($stable(accOut) && $stable({afOut, cfOut, sfOut, zfOut, pfOut})));

  assert_unp_flags_R3: assert property (@(posedge clk) disable iff (!rstN)
    (adjValid && !adjOp[1]) |=> (afOut == cfOut));

  assert_unp_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (adjValid && !adjOp[1]) |=>
      (accOut[BYTE_W-1:NIB_W] == '0 && !sfOut && !zfOut && !pfOut));

  assert_div_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    (adjValid && adjOp == 2'b10) |=> (accOut[2*BYTE_W-1:BYTE_W] == '0));

  assert_div_flags_R7: assert property (@(posedge clk) disable iff (!rstN)
    (adjValid && adjOp == 2'b10) |=> (!afOut && !cfOut));

  assert_pkd_high_R10: assert property (@(posedge clk) disable iff (!rstN)
    (adjValid && adjOp == 2'b11) |=>
      (accOut[2*BYTE_W-1:BYTE_W] == $past(accIn[2*BYTE_W-1:BYTE_W])));

  assert_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (adjValid && adjOp[1]) |=> (zfOut == (accOut[BYTE_W-1:0] == '0)));

  assert_parity_R11: assert property (@(posedge clk) disable iff (!rstN)
    (adjValid && adjOp[1]) |=> (pfOut == ~(^accOut[BYTE_W-1:0])));

endmodule

bind dec_adj_unit dec_adj_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .adjValid (adjValid),
  .adjOp    (adjOp),
  .accIn    (accIn),
  .accOut   (accOut),
  .afOut    (afOut),
  .cfOut    (cfOut),
  .sfOut    (sfOut),
  .zfOut    (zfOut),
  .pfOut    (pfOut)
);

// File: tb/tb_dec_adj_unit.sv
module tb_dec_adj_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        adjValid = 1'b0;
  logic [1:0]  adjOp = 2'b00;
  logic [15:0] accIn = '0;
  logic        afIn = 1'b0;
  logic        cfIn = 1'b0;
  logic [15:0] accOut;
  logic        afOut, cfOut, sfOut, zfOut, pfOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dec_adj_unit dut (
    .clk(clk), .rstN(rstN), .adjValid(adjValid), .adjOp(adjOp),
    .accIn(accIn), .afIn(afIn), .cfIn(cfIn), .accOut(accOut),
    .afOut(afOut), .cfOut(cfOut), .sfOut(sfOut), .zfOut(zfOut), .pfOut(pfOut)
  );

  // {op[2], acc[16], af, cf, expAcc[16], expFlags{af,cf,sf,zf,pf}[5]}
  localparam int NVEC = 16;
  localparam logic [40:0] VEC [NVEC] = '{
    {2'b00, 16'h000B, 1'b0, 1'b0, 16'h0101, 5'b11000}, // R3 nibble > 9
    {2'b00, 16'h0235, 1'b0, 1'b0, 16'h0205, 5'b00000}, // R3 no fix, R5 mask
    {2'b00, 16'h0312, 1'b1, 1'b0, 16'h0408, 5'b11000}, // R3 AF forces fix
    {2'b00, 16'h00FA, 1'b0, 1'b0, 16'h0100, 5'b11000}, // R3 low byte wraps
    {2'b01, 16'h020F, 1'b0, 1'b0, 16'h0109, 5'b11000}, // R4
    {2'b01, 16'h0003, 1'b1, 1'b0, 16'hFF0D, 5'b11000}, // R4 high wraps
    {2'b01, 16'h0537, 1'b0, 1'b0, 16'h0507, 5'b00000}, // R4 no fix
    {2'b10, 16'h0709, 1'b1, 1'b1, 16'h004F, 5'b00000}, // R6 79
    {2'b10, 16'h0000, 1'b0, 1'b0, 16'h0000, 5'b00011}, // R7 zero
    {2'b10, 16'h0D0E, 1'b0, 1'b0, 16'h0090, 5'b00101}, // R7 sign
    {2'b10, 16'h1A00, 1'b0, 1'b0, 16'h0004, 5'b00000}, // R6 wraps mod 256
    {2'b11, 16'h1279, 1'b0, 1'b0, 16'h1279, 5'b00000}, // R10 no fix
    {2'b11, 16'h002E, 1'b0, 1'b0, 16'h0034, 5'b10000}, // R8
    {2'b11, 16'h009A, 1'b0, 1'b0, 16'h0000, 5'b11011}, // R9 both steps
    {2'b11, 16'h0023, 1'b0, 1'b1, 16'h0083, 5'b01100}, // R9 CF in
    {2'b11, 16'h0585, 1'b1, 1'b0, 16'h058B, 5'b10101}  // R9 uses original byte
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [15:0] acc, input logic af, input logic cf);
    @(negedge clk);
    adjOp = op; accIn = acc; afIn = af; cfIn = cf; adjValid = 1'b1;
    @(negedge clk);
    adjValid = 1'b0;
  endtask

  function automatic string accTag(input logic [1:0] op);
    case (op)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R6";
      default: return "R8 R9";
    endcase
  endfunction

  function automatic string flagTag(input logic [1:0] op);
    case (op)
      2'b00, 2'b01: return "R5";
      2'b10: return "R7";
      default: return "R10";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 acc", accOut, 16'h0000);
    check("R1 flags", {11'b0, afOut, cfOut, sfOut, zfOut, pfOut}, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {11'b0, afOut, cfOut, sfOut, zfOut, pfOut} | accOut, 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][40:39], VEC[i][38:23], VEC[i][22], VEC[i][21]);
      check(accTag(VEC[i][40:39]), accOut, VEC[i][20:5]);
      check(flagTag(VEC[i][40:39]), {11'b0, afOut, cfOut, sfOut, zfOut, pfOut},
            {11'b0, VEC[i][4:0]});
      if (VEC[i][40]) check("R11 parity", {15'b0, pfOut}, {15'b0, VEC[i][0]});
    end

    // R2: no strobe, inputs change, outputs hold (last result 058B, flags 10101)
    @(negedge clk);
    adjOp = 2'b00; accIn = 16'h00FF; afIn = 1'b1; cfIn = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 hold acc", accOut, 16'h058B);
    check("R2 hold flags", {11'b0, afOut, cfOut, sfOut, zfOut, pfOut}, 16'h0015);

    // R2: result appears one edge after the strobe, not before
    @(negedge clk);
    adjOp = 2'b10; accIn = 16'h0203; adjValid = 1'b1;
    check("R2 not yet", accOut, 16'h058B);
    @(negedge clk);
    adjValid = 1'b0;
    check("R2 latency R6", accOut, 16'h0017);

    // R1: reset in mid-run clears outputs
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 re-reset", accOut, 16'h0000);
    rstN = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule